// File: doc/BRIEF.md
# SMBus Word Register Slave

This block is a target-only SMBus port that gives a host access to a small bank of 16-bit control registers. It watches oversampled SCL and SDA lines, finds START and STOP conditions, and answers a single fixed address. A host writes a register with a Write-Word transaction: address with the write bit, a command byte, then the data low byte and the data high byte. It reads a register with a Read-Word transaction: address with the write bit, the command byte, a repeated START, the address with the read bit, and then two bytes that the block sends.

Two identification words sit at fixed commands and cannot be written. The port is live only while both enable inputs are high. These inputs report that the supply is above its undervoltage lockout and that the adapter is detected. When the port is disabled, the bus is ignored. The block never starts a transfer, never stretches the clock and drives SDA only low, so the pad is open-drain. Both bus inputs pass through a two-flop synchronizer and a three-sample glitch filter before any edge is decoded.

Top module: `smbus_word_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every register in `regs_o` reads 0x0000.
- R2: An address byte of 0x12 (write) or 0x13 (read), sent MSB first, is acknowledged by pulling SDA low during the ninth SCL clock.
- R3: Any other address byte is not acknowledged. The block then ignores the bus until the next START: it acknowledges no further byte and changes no register.
- R4: In a Write-Word to a command in CMD_BASE..CMD_BASE+NUM_REGS-1 (default 0x10..0x13), the command byte and both data bytes are acknowledged. The first data byte becomes bits 7:0 and the second becomes bits 15:8 of register (command − CMD_BASE), which appears at `regs_o[16*k +: 16]`.
- R5: In a Read-Word, after a repeated START with address 0x13, the block returns bits 7:0 and then bits 15:8 of the addressed register, each byte MSB first.
- R6: A read of command 0xFF returns DEV_ID (default 0x00C3) and a read of command 0xFE returns MFG_ID (default 0x5A17). A Write-Word to either command is acknowledged but changes nothing.
- R7: A Write-Word to any other command is acknowledged but discarded, and a read of such a command returns 0x0000.
- R8: When the host does not acknowledge a byte that the block sent, the block releases SDA and sends nothing more until the next START. After a STOP, SDA is released.
- R9: While either `en_supply` or `en_adapter` is low, the block acknowledges nothing, changes no register and keeps SDA released.
- R10: A pulse of two system clocks or less on SCL or SDA has no effect on the transfer.
- R11: The block starts pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_supply | input | 1 | Supply above undervoltage lockout |
| en_adapter | input | 1 | Adapter detect above its threshold |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*16 | Flat view of the writable registers, register k at bits 16*k+15:16*k |

## Verification
A wrong byte counter or phase state shows up at the pins within one byte time. The acknowledge slot moves or goes missing, so the host sees NACK on a byte that should be accepted, or the bus stays low when the host tries a STOP. A corrupted shift register or command latch appears only at the end of the transaction: either the register image on `regs_o` changes after the high data byte, or the two bytes of a later Read-Word come back wrong. For this reason every write in the bench is followed by a read-back. An enable or filter fault shows as an acknowledge that should not happen, or a lost one, in the very first byte after the disturbance.

// File: rtl/smbus_word_pkg.sv
package smbus_word_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } phase_e;

    typedef enum logic [2:0] {
        B_ADDR,
        B_CMD,
        B_WLO,
        B_WHI,
        B_RLO,
        B_RHI
    } byte_e;

    typedef struct packed {
        phase_e     st;
        byte_e      bidx;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] cmd;
        logic [7:0] lo;
        logic       rw;
        logic       mack;
        logic       oe;
    } ctl_t;

endpackage

// File: rtl/smbus_deglitch.sv
module smbus_deglitch #(
    parameter int SYNC  = 2,
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic [SYNC-1:0]  sync_d, sync_q;
    logic [DEPTH-1:0] hist_d, hist_q;
    logic             filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SYNC-2:0], raw_i};
        hist_d = {hist_q[DEPTH-2:0], sync_q[SYNC-1]};
        filt_d = filt_q;
        if (&hist_q)       filt_d = 1'b1;
        else if (~|hist_q) filt_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            filt_q <= filt_d;
        end
    end

    assign filt_o = filt_q;

    AST_NO_CHATTER: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |=> $stable(filt_q)); // R10
endmodule

// File: rtl/smbus_bus_events.sv
module smbus_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_p_d, scl_p_q;
    logic sda_p_d, sda_p_q;

    always_comb begin
        scl_p_d = scl_f;
        sda_p_d = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end

    assign ev_start = scl_f & scl_p_q & sda_p_q & ~sda_f;
    assign ev_stop  = scl_f & scl_p_q & ~sda_p_q & sda_f;
    assign ev_rise  = scl_f & ~scl_p_q;
    assign ev_fall  = ~scl_f & scl_p_q;
endmodule

// File: rtl/smbus_word_regs.sv
module smbus_word_regs #(
    parameter int          NUM_REGS = 4,
    parameter logic [7:0]  CMD_BASE = 8'h10,
    parameter logic [15:0] DEV_ID   = 16'h00C3,
    parameter logic [15:0] MFG_ID   = 16'h5A17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [7:0]            cmd_i,
    input  logic [15:0]           wdata_i,
    output logic [15:0]           rdata_o,
    output logic [NUM_REGS*16-1:0] regs_o
);
    localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] LO_CMD = {1'b0, CMD_BASE};
    localparam logic [8:0] HI_CMD = LO_CMD + 9'(NUM_REGS);

    logic [15:0]     regs_d [NUM_REGS];
    logic [15:0]     regs_q [NUM_REGS];
    logic            hit;
    logic [7:0]      offs;
    logic [IDXW-1:0] idx;

    assign hit  = ({1'b0, cmd_i} >= LO_CMD) && ({1'b0, cmd_i} < HI_CMD);
    assign offs = cmd_i - CMD_BASE;
    assign idx  = offs[IDXW-1:0];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
        if (we_i && hit) regs_d[idx] = wdata_i;
        if (hit)                rdata_o = regs_q[idx];
        else if (cmd_i == 8'hFF) rdata_o = DEV_ID;
        else if (cmd_i == 8'hFE) rdata_o = MFG_ID;
        else                    rdata_o = 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 16'h0000;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*16 +: 16] = regs_q[g];
    end

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_o)); // R7
endmodule

// File: rtl/smbus_word_slave.sv
module smbus_word_slave
    import smbus_word_pkg::*;
#(
    parameter logic [6:0]  ADDR7    = 7'h09,
    parameter int          NUM_REGS = 4,
    parameter logic [7:0]  CMD_BASE = 8'h10,
    parameter logic [15:0] DEV_ID   = 16'h00C3,
    parameter logic [15:0] MFG_ID   = 16'h5A17,
    parameter int          SYNC     = 2,
    parameter int          DEPTH    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_supply,
    input  logic                   en_adapter,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NUM_REGS*16-1:0] regs_o
);
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic bus_en, wr_en;
    logic [15:0] rdata;
    ctl_t c_d, c_q;

    assign bus_en = en_supply & en_adapter;

    smbus_deglitch #(.SYNC(SYNC), .DEPTH(DEPTH)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f));
    smbus_deglitch #(.SYNC(SYNC), .DEPTH(DEPTH)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f));

    smbus_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

    smbus_word_regs #(.NUM_REGS(NUM_REGS), .CMD_BASE(CMD_BASE),
                      .DEV_ID(DEV_ID), .MFG_ID(MFG_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .cmd_i(c_q.cmd),
        .wdata_i({c_q.sh, c_q.lo}), .rdata_o(rdata), .regs_o(regs_o));

    always_comb begin
        c_d   = c_q;
        wr_en = 1'b0;
        if (!bus_en) begin
            c_d.st = S_IDLE;
            c_d.oe = 1'b0;
        end else if (ev_start) begin
            c_d.st   = S_RX;
            c_d.bidx = B_ADDR;
            c_d.cnt  = '0;
            c_d.oe   = 1'b0;
        end else if (ev_stop) begin
            c_d.st = S_IDLE;
            c_d.oe = 1'b0;
        end else begin
            case (c_q.st)
                S_RX: begin
                    if (ev_rise && c_q.cnt != 4'd8) begin
                        c_d.sh  = {c_q.sh[6:0], sda_f};
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (ev_fall && c_q.cnt == 4'd8) begin
                        c_d.st = S_ACK;
                        c_d.oe = 1'b1;
                        case (c_q.bidx)
                            B_ADDR: begin
                                if (c_q.sh[7:1] == ADDR7) c_d.rw = c_q.sh[0];
                                else begin
                                    c_d.st = S_IDLE;
                                    c_d.oe = 1'b0;
                                end
                            end
                            B_CMD: c_d.cmd = c_q.sh;
                            B_WLO: c_d.lo  = c_q.sh;
                            B_WHI: wr_en   = 1'b1;
                            default: begin
                                c_d.st = S_IDLE;
                                c_d.oe = 1'b0;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (ev_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        c_d.st  = S_RX;
                        case (c_q.bidx)
                            B_ADDR: begin
                                if (c_q.rw) begin
                                    c_d.bidx = B_RLO;
                                    c_d.st   = S_TX;
                                    c_d.sh   = rdata[7:0];
                                    c_d.oe   = ~rdata[7];
                                end else begin
                                    c_d.bidx = B_CMD;
                                end
                            end
                            B_CMD:   c_d.bidx = B_WLO;
                            B_WLO:   c_d.bidx = B_WHI;
                            default: c_d.st   = S_IDLE;
                        endcase
                    end
                end
                S_TX: begin
                    if (ev_rise) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (ev_fall) begin
                        if (c_q.cnt == 4'd8) begin
                            c_d.oe = 1'b0;
                            c_d.st = S_MACK;
                        end else begin
                            c_d.sh = {c_q.sh[6:0], 1'b0};
                            c_d.oe = ~c_q.sh[6];
                        end
                    end
                end
                S_MACK: begin
                    if (ev_rise) begin
                        c_d.mack = ~sda_f;
                    end else if (ev_fall) begin
                        if (c_q.bidx == B_RLO && c_q.mack) begin
                            c_d.bidx = B_RHI;
                            c_d.st   = S_TX;
                            c_d.cnt  = '0;
                            c_d.sh   = rdata[15:8];
                            c_d.oe   = ~rdata[15];
                        end else begin
                            c_d.st = S_IDLE;
                            c_d.oe = 1'b0;
                        end
                    end
                end
                default: c_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, bidx: B_ADDR, cnt: 4'd0, sh: 8'h00,
                     cmd: 8'h00, lo: 8'h00, rw: 1'b0, mack: 1'b0, oe: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe = c_q.oe;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !sda_oe); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_IDLE) |-> !sda_oe); // R3
    AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f); // R11
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && ev_stop) |=> !sda_oe); // R8
endmodule

// File: tb/tb_smbus_word_slave.sv
module tb_smbus_word_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 4;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] BASE = 8'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_supply = 1'b1;
    logic en_adapter = 1'b1;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic [NREG*16-1:0] regs_o;
    wire  sda_bus = msda & ~sda_oe;
    logic glitch_on = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_word_slave dut (
        .clk(clk), .rst_n(rst_n), .en_supply(en_supply), .en_adapter(en_adapter),
        .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe), .regs_o(regs_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        msda = b;
        if (glitch_on) begin
            wq(2); scl = 1'b1; wq(2); scl = 1'b0; wq(Q-4);
        end else wq(Q);
        scl = 1'b1;
        if (glitch_on && b) begin
            wq(4); msda = 1'b0; wq(2); msda = 1'b1; wq(2*Q-6);
        end else wq(2*Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        msda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        b = sda_bus; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        msda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        msda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        msda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(~ack);
    endtask

    task automatic write_word(input logic [7:0] adr, input logic [7:0] cmd,
                              input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(adr, acks[3]);
        send_byte(cmd, acks[2]);
        send_byte(d[7:0], acks[1]);
        send_byte(d[15:8], acks[0]);
        bus_stop();
    endtask

    task automatic read_word(input logic [7:0] cmd, output logic [15:0] d,
                             output logic [2:0] acks);
        bus_start();
        send_byte(8'h12, acks[2]);
        send_byte(cmd, acks[1]);
        bus_start();
        send_byte(8'h13, acks[0]);
        recv_byte(d[7:0], 1'b1);
        recv_byte(d[15:8], 1'b0);
        bus_stop();
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NREG; k++) check(req, 32'(regs_o[k*16 +: 16]), 32'(model[k]));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic       a;
        logic [3:0] wa;
        logic [2:0] ra;
        logic [15:0] rd;
        logic [7:0]  xb;
        logic [15:0] v;

        for (int k = 0; k < NREG; k++) model[k] = 16'h0000;
        wq(5);
        check("R1 sda_oe at reset", 32'(sda_oe), 32'd0);
        check_regs("R1 registers at reset");
        rst_n = 1'b1;
        wq(10);

        // R2 / R3: sweep of every address byte value
        for (int ab = 0; ab < 256; ab++) begin
            bus_start();
            send_byte(8'(ab), a);
            if (a && ab[0]) recv_byte(xb, 1'b0);
            bus_stop();
            check((ab[7:1] == 7'h09) ? "R2 address ack" : "R3 address nack",
                  32'(a), 32'(ab[7:1] == 7'h09));
        end

        // R4 / R5: write then read back each implemented register
        for (int k = 0; k < NREG; k++) begin
            v = 16'((k + 1) * 16'h1357) ^ 16'hC0DE;
            model[k] = v;
            write_word(8'h12, BASE + 8'(k), v, wa);
            check("R4 write acks", 32'(wa), 32'hF);
            check_regs("R4 register image");
        end
        for (int k = 0; k < NREG; k++) begin
            read_word(BASE + 8'(k), rd, ra);
            check("R5 read acks", 32'(ra), 32'h7);
            check("R5 read data", 32'(rd), 32'(model[k]));
        end

        // R6: identification words, writes discarded
        write_word(8'h12, 8'hFF, 16'h1234, wa);
        check("R6 id write acked", 32'(wa), 32'hF);
        write_word(8'h12, 8'hFE, 16'h4321, wa);
        check("R6 id write acked", 32'(wa), 32'hF);
        read_word(8'hFF, rd, ra);
        check("R6 device id", 32'(rd), 32'h00C3);
        read_word(8'hFE, rd, ra);
        check("R6 maker id", 32'(rd), 32'h5A17);
        check_regs("R6 registers untouched");

        // R7: unimplemented commands
        for (int u = 0; u < 3; u++) begin
            logic [7:0] uc;
            uc = (u == 0) ? BASE + 8'(NREG) : (u == 1) ? 8'h80 : BASE - 8'd1;
            write_word(8'h12, uc, 16'hBEEF, wa);
            check("R7 unimplemented write acked", 32'(wa), 32'hF);
            check_regs("R7 write discarded");
            read_word(uc, rd, ra);
            check("R7 unimplemented read", 32'(rd), 32'h0000);
        end

        // R3: wrong address, rest of the transaction ignored
        write_word(8'h24, BASE, 16'hFFFF, wa);
        check("R3 no ack after wrong address", 32'(wa), 32'h0);
        check_regs("R3 registers untouched");

        // R8: host NACKs the low byte, block sends nothing further
        model[0] = 16'h0001;
        write_word(8'h12, BASE, 16'h0001, wa);
        bus_start();
        send_byte(8'h12, a);
        send_byte(BASE, a);
        bus_start();
        send_byte(8'h13, a);
        recv_byte(xb, 1'b0);
        check("R8 low byte before nack", 32'(xb), 32'h01);
        recv_byte(xb, 1'b0);
        check("R8 bus released after nack", 32'(xb), 32'hFF);
        bus_stop();
        wq(Q);
        check("R8 sda released after stop", 32'(sda_oe), 32'd0);

        // R9: enable gating
        en_adapter = 1'b0;
        write_word(8'h12, BASE + 8'd1, 16'h5555, wa);
        check("R9 no ack adapter low", 32'(wa), 32'h0);
        en_adapter = 1'b1;
        en_supply = 1'b0;
        write_word(8'h12, BASE + 8'd1, 16'h6666, wa);
        check("R9 no ack supply low", 32'(wa), 32'h0);
        en_supply = 1'b1;
        wq(Q);
        check_regs("R9 registers untouched");
        read_word(BASE + 8'd1, rd, ra);
        check("R9 readback after re-enable", 32'(rd), 32'(model[1]));

        // R10: short pulses on both lines
        glitch_on = 1'b1;
        model[2] = 16'hA5F0;
        write_word(8'h12, BASE + 8'd2, 16'hA5F0, wa);
        check("R10 acks with glitches", 32'(wa), 32'hF);
        read_word(BASE + 8'd2, rd, ra);
        glitch_on = 1'b0;
        check("R10 data with glitches", 32'(rd), 32'hA5F0);
        check_regs("R10 register image");

        finish_run();
    end
endmodule